// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block sits between a single 16-bit instruction fetch port and the decode stage of an in-order pipeline. Every cycle it presents one fetch address. It then sorts the returned word into one of two kinds. The word is either a complete short instruction or the leading half of a long, 32-bit instruction. A short instruction is registered and handed to decode. A leading half is held inside the sequencer, and decode receives a no-operation bubble in its place. On the following fetch the sequencer joins the held half and the newly fetched word into one 32-bit instruction and releases it.

The fetch address advances by one word for every fetch that is accepted, and this includes the fetch of a trailing half. A stall from later stages freezes the address, the held half and the decode register together. A flush from a taken branch loads a new address and discards any half-assembled instruction. A flush also takes priority over a stall. The instruction memory and the decoding of operations lie outside this block.

Top module: `vlf_fetch_seq`

## Requirements
- R1: While reset is asserted, the fetch address equals the RESET_PC parameter, decode receives a bubble (`dec_bubble_o`=1, `dec_long_o`=0) and `dec_insn_o` carries NOP_WORD zero-extended to 32 bits.
- R2: An accepted fetch of a word whose bits [15:12] differ from 4'hE, with no half pending, appears one cycle later as `dec_insn_o` = {16'h0, word}, with `dec_long_o`=0, `dec_bubble_o`=0 and `dec_pc_o` equal to the address of that word.
- R3: An accepted fetch of a word whose bits [15:12] equal 4'hE, with no half pending, is held as a leading half, and one cycle later decode receives a bubble carrying the zero-extended NOP_WORD.
- R4: The accepted fetch that follows a held leading half appears one cycle later as `dec_insn_o` = {leading, trailing}, with `dec_long_o`=1, `dec_bubble_o`=0 and `dec_pc_o` equal to the address of the leading half. The opcode field of the trailing word is ignored, so a trailing word that starts with 4'hE does not begin a new long instruction.
- R5: Each accepted fetch, including the fetch of a trailing half, advances the fetch address by exactly one word, and the address wraps modulo 2^PC_W.
- R6: While `stall_i` is high and `flush_i` is low, the fetch address, the held half and all decode outputs keep their values.
- R7: A cycle with `flush_i` high loads `flush_pc_i` into the fetch address, drops any held leading half and sends a NOP bubble to decode one cycle later. This happens even when `stall_i` is high in the same cycle.
- R8: `dec_long_o` and `dec_bubble_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc_o | output | PC_W | Word address sent to instruction memory |
| fetch_word_i | input | WORD_W | Word returned for `fetch_pc_o` in the same cycle |
| stall_i | input | 1 | Hold request from later stages |
| flush_i | input | 1 | Redirect request from branch resolution |
| flush_pc_i | input | PC_W | New fetch address on a flush |
| dec_insn_o | output | 2*WORD_W | Instruction handed to decode; short ones sit in the low half |
| dec_long_o | output | 1 | Decode slot holds a 32-bit instruction |
| dec_bubble_o | output | 1 | Decode slot holds an inserted NOP |
| dec_pc_o | output | PC_W | Address of the first word of the instruction in the decode slot |

## Verification
Most internal faults show at the ports one cycle after the fetch that triggers them. A pending flag stuck high or stuck low appears in the next decode slot as a missing bubble, a spurious long instruction, or a pair of halves in the wrong order. A lost or extra address increment shows on the fetch address at once and moves every later instruction by one word. For that reason the bench compares the fetch address and the decode slot against an arithmetic model on every cycle. It runs over an address space small enough to wrap, with adjacent prefix words and with stalls and flushes that land on either half of a long instruction.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

  typedef enum logic {
    WCLS_SHORT  = 1'b0,
    WCLS_PREFIX = 1'b1
  } word_cls_e;

endpackage

// File: rtl/vlf_classify.sv
module vlf_classify
  import vlf_pkg::*;
#(
  parameter int unsigned              WORD_W     = 16,
  parameter int unsigned              OPC_W      = 4,
  parameter logic [OPC_W-1:0]         PREFIX_OPC = 4'hE
) (
  input  logic [WORD_W-1:0] word_i,
  output word_cls_e         cls_o
);

  localparam int unsigned OPC_LSB = WORD_W - OPC_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc   = word_i[WORD_W-1:OPC_LSB];
    cls_o = (opc == PREFIX_OPC) ? WCLS_PREFIX : WCLS_SHORT;
  end

endmodule

// File: rtl/vlf_pc.sv
module vlf_pc #(
  parameter int unsigned       PC_W     = 16,
  parameter logic [PC_W-1:0]   RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            flush_i,
  input  logic [PC_W-1:0] flush_pc_i,
  output logic [PC_W-1:0] pc_o
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  always_comb begin
    pc_en = flush_i | adv_i;
    pc_d  = flush_i ? flush_pc_i : (pc_q + PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !flush_i) |=> (pc_q == PC_W'($past(pc_q) + PC_STEP)));

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !flush_i) |=> $stable(pc_q));

  // R7
  pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (pc_q == $past(flush_pc_i)));

endmodule

// File: rtl/vlf_assemble.sv
module vlf_assemble
  import vlf_pkg::*;
#(
  parameter int unsigned         WORD_W   = 16,
  parameter int unsigned         PC_W     = 16,
  parameter logic [WORD_W-1:0]   NOP_WORD = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stall_i,
  input  logic                  flush_i,
  input  word_cls_e             cls_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic [PC_W-1:0]       pc_i,
  output logic [2*WORD_W-1:0]   insn_o,
  output logic                  long_o,
  output logic                  bubble_o,
  output logic [PC_W-1:0]       dpc_o
);

  localparam int unsigned              INSN_W   = 2 * WORD_W;
  localparam logic [INSN_W-1:0]        NOP_INSN = {{WORD_W{1'b0}}, NOP_WORD};

  // held leading half
  logic                  pend_q, pend_d;
  logic [WORD_W-1:0]     lead_q, lead_d;
  logic [PC_W-1:0]       lpc_q, lpc_d;
  // decode slot
  logic [INSN_W-1:0]     insn_q, insn_d;
  logic                  long_q, long_d;
  logic                  bub_q, bub_d;
  logic [PC_W-1:0]       dpc_q, dpc_d;
  logic                  en;

  always_comb begin
    en     = flush_i | ~stall_i;
    pend_d = pend_q;
    lead_d = lead_q;
    lpc_d  = lpc_q;
    insn_d = insn_q;
    long_d = long_q;
    bub_d  = bub_q;
    dpc_d  = dpc_q;
    if (flush_i) begin
      pend_d = 1'b0;
      insn_d = NOP_INSN;
      long_d = 1'b0;
      bub_d  = 1'b1;
    end else if (!stall_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
        insn_d = {lead_q, word_i};
        long_d = 1'b1;
        bub_d  = 1'b0;
        dpc_d  = lpc_q;
      end else if (cls_i == WCLS_PREFIX) begin
        pend_d = 1'b1;
        lead_d = word_i;
        lpc_d  = pc_i;
        insn_d = NOP_INSN;
        long_d = 1'b0;
        bub_d  = 1'b1;
        dpc_d  = pc_i;
      end else begin
        insn_d = {{WORD_W{1'b0}}, word_i};
        long_d = 1'b0;
        bub_d  = 1'b0;
        dpc_d  = pc_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lead_q <= '0;
      lpc_q  <= '0;
      insn_q <= NOP_INSN;
      long_q <= 1'b0;
      bub_q  <= 1'b1;
      dpc_q  <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      lead_q <= lead_d;
      lpc_q  <= lpc_d;
      insn_q <= insn_d;
      long_q <= long_d;
      bub_q  <= bub_d;
      dpc_q  <= dpc_d;
    end
  end

  assign insn_o   = insn_q;
  assign long_o   = long_q;
  assign bubble_o = bub_q;
  assign dpc_o    = dpc_q;

  // R3
  prefix_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !flush_i && !pend_q && cls_i == WCLS_PREFIX) |=> (bub_q && pend_q));

  // R4
  join_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !flush_i && pend_q) |=> (long_q && !pend_q && insn_q[WORD_W-1:0] == $past(word_i)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !flush_i) |=> ($stable(insn_q) && $stable(pend_q) && $stable(bub_q)));

  // R7
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (bub_q && !pend_q && insn_q == NOP_INSN));

  // R8
  kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(long_q && bub_q));

endmodule

// File: rtl/vlf_fetch_seq.sv
module vlf_fetch_seq
  import vlf_pkg::*;
#(
  parameter int unsigned         WORD_W     = 16,
  parameter int unsigned         PC_W       = 16,
  parameter int unsigned         OPC_W      = 4,
  parameter logic [OPC_W-1:0]    PREFIX_OPC = 4'hE,
  parameter logic [WORD_W-1:0]   NOP_WORD   = '0,
  parameter logic [PC_W-1:0]     RESET_PC   = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PC_W-1:0]       fetch_pc_o,
  input  logic [WORD_W-1:0]     fetch_word_i,
  input  logic                  stall_i,
  input  logic                  flush_i,
  input  logic [PC_W-1:0]       flush_pc_i,
  output logic [2*WORD_W-1:0]   dec_insn_o,
  output logic                  dec_long_o,
  output logic                  dec_bubble_o,
  output logic [PC_W-1:0]       dec_pc_o
);

  word_cls_e       cls;
  logic [PC_W-1:0] pc;
  logic            adv;

  assign adv        = ~stall_i;
  assign fetch_pc_o = pc;

  vlf_classify #(
    .WORD_W     (WORD_W),
    .OPC_W      (OPC_W),
    .PREFIX_OPC (PREFIX_OPC)
  ) u_classify (
    .word_i (fetch_word_i),
    .cls_o  (cls)
  );

  vlf_pc #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv),
    .flush_i    (flush_i),
    .flush_pc_i (flush_pc_i),
    .pc_o       (pc)
  );

  vlf_assemble #(
    .WORD_W   (WORD_W),
    .PC_W     (PC_W),
    .NOP_WORD (NOP_WORD)
  ) u_assemble (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_i  (stall_i),
    .flush_i  (flush_i),
    .cls_i    (cls),
    .word_i   (fetch_word_i),
    .pc_i     (pc),
    .insn_o   (dec_insn_o),
    .long_o   (dec_long_o),
    .bubble_o (dec_bubble_o),
    .dpc_o    (dec_pc_o)
  );

endmodule

// File: tb/test_vlf_fetch_seq.sv
module test_vlf_fetch_seq;

  localparam int unsigned PW    = 8;
  localparam int unsigned WW    = 16;
  localparam logic [PW-1:0] RPC = 8'h10;
  localparam logic [WW-1:0] NOPW = 16'h0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] fetch_pc;
  logic [WW-1:0] fetch_word;
  logic          stall, flush;
  logic [PW-1:0] flush_pc;
  logic [31:0]   dec_insn;
  logic          dec_long, dec_bub;
  logic [PW-1:0] dec_pc;

  logic [WW-1:0] mem [256];

  int n_run  = 0;
  int n_fail = 0;

  // expected model state
  logic [PW-1:0] e_pc, e_fpc, e_dpc;
  logic          e_pend, e_long, e_bub;
  logic [WW-1:0] e_first;
  logic [31:0]   e_insn;
  string         e_tag, p_tag;

  always #10 clk = ~clk;

  assign fetch_word = mem[fetch_pc];

  vlf_fetch_seq #(
    .WORD_W (WW), .PC_W (PW), .OPC_W (4), .PREFIX_OPC (4'hE),
    .NOP_WORD (NOPW), .RESET_PC (RPC)
  ) i_vlf_fetch_seq (
    .clk (clk), .rst_n (rst_n), .fetch_pc_o (fetch_pc), .fetch_word_i (fetch_word),
    .stall_i (stall), .flush_i (flush), .flush_pc_i (flush_pc),
    .dec_insn_o (dec_insn), .dec_long_o (dec_long), .dec_bubble_o (dec_bub),
    .dec_pc_o (dec_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({e_tag, " insn"},   dec_insn, e_insn);
    chk({e_tag, " long"},   32'(dec_long), 32'(e_long));
    chk({e_tag, " bubble"}, 32'(dec_bub), 32'(e_bub));
    if (!e_bub) chk({e_tag, " dec_pc"}, 32'(dec_pc), 32'(e_dpc));
    chk({p_tag, " fetch_pc"}, 32'(fetch_pc), 32'(e_pc));
    // R8
    chk("R8 exclusive", 32'(dec_long & dec_bub), 32'h0);
  endtask

  // caller sits at a negedge
  task automatic step(input logic st, input logic fl, input logic [PW-1:0] tgt);
    logic [WW-1:0] w;
    stall    = st;
    flush    = fl;
    flush_pc = tgt;
    if (fl) begin
      e_pc = tgt; e_pend = 1'b0;
      e_insn = {16'h0, NOPW}; e_long = 1'b0; e_bub = 1'b1;
      e_tag = "R7"; p_tag = "R7";
    end else if (st) begin
      e_tag = "R6"; p_tag = "R6";
    end else begin
      w = mem[e_pc];
      if (e_pend) begin
        e_insn = {e_first, w}; e_long = 1'b1; e_bub = 1'b0; e_dpc = e_fpc;
        e_pend = 1'b0; e_tag = "R4";
      end else if (w[15:12] == 4'hE) begin
        e_pend = 1'b1; e_first = w; e_fpc = e_pc;
        e_insn = {16'h0, NOPW}; e_long = 1'b0; e_bub = 1'b1; e_tag = "R3";
      end else begin
        e_insn = {16'h0, w}; e_long = 1'b0; e_bub = 1'b0; e_dpc = e_pc;
        e_tag = "R2";
      end
      e_pc = e_pc + 8'd1; p_tag = "R5";
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // image: runs of prefix words (some back to back) among short words
    for (int i = 0; i < 256; i++) begin
      logic [3:0] op;
      op = (i % 5 < 2) ? 4'hE : 4'(i % 14);
      mem[i] = {op, 4'(i), 8'(i * 3 + 1)};
    end
    rst_n = 1'b0; stall = 1'b0; flush = 1'b0; flush_pc = '0;
    #25;
    // R1 reset values
    e_pc = RPC; e_pend = 1'b0; e_first = '0; e_fpc = '0; e_dpc = '0;
    e_insn = {16'h0, NOPW}; e_long = 1'b0; e_bub = 1'b1;
    e_tag = "R1"; p_tag = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    // plain sweep, wraps the address space
    for (int k = 0; k < 600; k++) step(1'b0, 1'b0, '0);
    // stalls landing on either half
    for (int k = 0; k < 600; k++) step(($urandom_range(0, 3) == 0), 1'b0, '0);
    // flushes, including flush together with stall
    for (int k = 0; k < 800; k++)
      step(($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0), 8'($urandom_range(0, 255)));
    // directed: flush right after a prefix drops the half
    step(1'b0, 1'b1, 8'd0);
    step(1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 8'd5);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule